// File: doc/BRIEF.md
# Floppy Drive Select and Motor Decode

This block holds the two host-visible control registers of a floppy controller's drive interface: a digital output register at offset 2 and a tape assignment register at offset 3. From the output register it decodes active-low drive-select and motor-on lines for two physical drives. It also produces the level that holds the command engine in soft reset, and it gates the DMA request, interrupt, acknowledge and terminal-count signals according to the host compatibility mode.

The host writes a byte in one clock with `wr_en` and reads it in the same cycle with `rd_en`. The read path returns a data byte with a per-bit output enable. Bits with the enable low stand for a floating bus, and they read as 0. A static `swap_en` input exchanges the roles of drive 0 and drive 1 on the decoded outputs.

Top module: `fdc_drvsel`

## Requirements
- R1: After hardware reset, both registers read 00h, `ctl_reset` is 1, and every `ds_n` and `mtr_n` output is 1.
- R2: A write at offset 2 stores all eight bits. A read at offset 2 returns that byte with `rdata_oe` = FFh. The bit layout, from bit 7 down to bit 0, is motor enables 3..0, DMA enable, run (active-low reset), and a 2-bit drive code.
- R3: `ctl_reset` equals the inverse of bit 2 of the output register. Writing 0 and then 1 to that bit gives a reset pulse, and the other bits read back unchanged.
- R4: When `swap_en`=0, `ds_n[0]` is 0 only for drive code 00 with bit 4 set, and `ds_n[1]` is 0 only for drive code 01 with bit 5 set.
- R5: When `swap_en`=0, `mtr_n[0]` is the inverse of bit 4 and `mtr_n[1]` is the inverse of bit 5.
- R6: When `swap_en`=1, `ds_n[1]` is 0 only for code 00 with bit 5 set, and `ds_n[0]` is 0 only for code 01 with bit 4 set. In this mode `mtr_n[0]` is the inverse of bit 5 and `mtr_n[1]` is the inverse of bit 4.
- R7: In AT mode (`mode_i`=0) and Model 30 mode (`mode_i`=2), a DMA enable bit (bit 3) of 0 forces `drq_oe`, `irq_oe`, `drq_out`, `irq_out`, `ack_out` and `tc_out` to 0. When the bit is 1, the oe lines are 1 and the four signals pass through.
- R8: In PS/2 mode (`mode_i`=1), the DMA and interrupt signals pass through with their oe lines at 1, whatever bit 3 holds.
- R9: A write at offset 3 keeps only data bits 1:0. A read at offset 3 returns them with `rdata_oe` = 03h and bits 7:2 at 0.
- R10: The tape register is not changed by a soft reset or by writes at offset 2.
- R11: The values 1Ch, 2Dh, 4Eh and 8Fh give `drv_code` 0, 1, 2 and 3 with `drv_motor`=1. 1Ch activates `ds_n[0]`/`mtr_n[0]`, 2Dh activates `ds_n[1]`/`mtr_n[1]`, and 4Eh and 8Fh leave both 2-drive outputs inactive.
- R12: Without `rd_en`, or with an address other than 2 or 3, `rdata_oe` and `rdata` are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mode_i | input | 2 | Host mode: 0 AT, 1 PS/2, 2 Model 30 |
| swap_en | input | 1 | Exchange drive 0 and drive 1 decode |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 8 | Per-bit read drive enable |
| ds_n | output | NDRV | Active-low drive selects |
| mtr_n | output | NDRV | Active-low motor-on lines |
| drv_code | output | 2 | Selected drive number |
| drv_motor | output | 1 | Motor bit of the selected drive |
| ctl_reset | output | 1 | Soft-reset level for the command engine |
| drq_in | input | 1 | DMA request from the engine |
| irq_in | input | 1 | Interrupt from the engine |
| ack_in | input | 1 | DMA acknowledge from the bus |
| tc_in | input | 1 | Terminal count from the bus |
| drq_out | output | 1 | Gated DMA request |
| drq_oe | output | 1 | DMA request drive enable |
| irq_out | output | 1 | Gated interrupt |
| irq_oe | output | 1 | Interrupt drive enable |
| ack_out | output | 1 | Gated acknowledge to the engine |
| tc_out | output | 1 | Gated terminal count to the engine |

## Verification
The assertions assume that the host never raises `wr_en` and `rd_en` in the same cycle. They also assume that `mode_i` and `swap_en` are held steady across the write whose effect they inspect, so the value captured one clock earlier is the value in force. The stimulus changes every input only at the falling clock edge and performs at most one access per cycle. It switches mode or swap only between accesses. The mode and swap settings are changed several times during the run, so each decode variant is seen after real writes.

// File: rtl/fdc_dsel_pkg.sv
package fdc_dsel_pkg;
  typedef enum logic [1:0] {
    HM_AT  = 2'd0,
    HM_PS2 = 2'd1,
    HM_M30 = 2'd2
  } host_mode_e;

  // physical output index -> register drive number
  function automatic logic [1:0] logical_drive(input int p, input logic swap);
    if (swap && p < 2) return 2'(p ^ 1);
    return 2'(p);
  endfunction

  function automatic logic pins_enabled(input host_mode_e m, input logic dma_bit);
    return (m == HM_PS2) || dma_bit;
  endfunction
endpackage

// File: rtl/fdc_dor_regs.sv
module fdc_dor_regs #(
  parameter int ADDR_W  = 3,
  parameter int DOR_OFS = 2,
  parameter int TDR_OFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        dor_q,
  output logic [7:0]        rdata,
  output logic [7:0]        rdata_oe
);
  localparam logic [ADDR_W-1:0] DOR_A = ADDR_W'(DOR_OFS);
  localparam logic [ADDR_W-1:0] TDR_A = ADDR_W'(TDR_OFS);

  logic [1:0] tdr_q;
  logic       hit_dor, hit_tdr;

  assign hit_dor = (addr == DOR_A);
  assign hit_tdr = (addr == TDR_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dor_q <= 8'h00;
      tdr_q <= 2'b00;
    end else if (wr_en) begin
      if (hit_dor) dor_q <= wdata;
      if (hit_tdr) tdr_q <= wdata[1:0];
    end
  end

  always_comb begin
    rdata    = 8'h00;
    rdata_oe = 8'h00;
    if (rd_en && hit_dor) begin
      rdata    = dor_q;
      rdata_oe = 8'hFF;
    end else if (rd_en && hit_tdr) begin
      rdata    = {6'b0, tdr_q};
      rdata_oe = 8'h03;
    end
  end

  // R10
  tdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_tdr) |=> $stable(tdr_q));
endmodule

// File: rtl/fdc_drive_decode.sv
module fdc_drive_decode
  import fdc_dsel_pkg::*;
#(
  parameter int NDRV = 2
) (
  input  logic [1:0]      sel,
  input  logic [3:0]      motor,
  input  logic            swap_en,
  output logic [NDRV-1:0] ds_n,
  output logic [NDRV-1:0] mtr_n,
  output logic [1:0]      drv_code,
  output logic            drv_motor
);
  for (genvar p = 0; p < NDRV; p++) begin : g_drv
    logic [1:0] lg;
    always_comb begin
      lg       = logical_drive(p, swap_en);
      ds_n[p]  = !((sel == lg) && motor[p]);
      mtr_n[p] = !motor[lg];
    end
  end

  assign drv_code  = sel;
  assign drv_motor = motor[sel];

  // R4 R6
  one_select_chk: assert final ($countones(~ds_n) <= 1);
endmodule

// File: rtl/fdc_dma_gate.sv
module fdc_dma_gate
  import fdc_dsel_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       dma_bit,
  input  logic       drq_in,
  input  logic       irq_in,
  input  logic       ack_in,
  input  logic       tc_in,
  output logic       pins_en,
  output logic       drq_out,
  output logic       drq_oe,
  output logic       irq_out,
  output logic       irq_oe,
  output logic       ack_out,
  output logic       tc_out
);
  host_mode_e mode;
  assign mode    = host_mode_e'(mode_i);
  assign pins_en = pins_enabled(mode, dma_bit);
  assign drq_oe  = pins_en;
  assign irq_oe  = pins_en;
  assign drq_out = pins_en & drq_in;
  assign irq_out = pins_en & irq_in;
  assign ack_out = pins_en & ack_in;
  assign tc_out  = pins_en & tc_in;
endmodule

// File: rtl/fdc_drvsel.sv
module fdc_drvsel
  import fdc_dsel_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DOR_OFS = 2,
  parameter int TDR_OFS = 3,
  parameter int NDRV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              swap_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        rdata_oe,
  output logic [NDRV-1:0]   ds_n,
  output logic [NDRV-1:0]   mtr_n,
  output logic [1:0]        drv_code,
  output logic              drv_motor,
  output logic              ctl_reset,
  input  logic              drq_in,
  input  logic              irq_in,
  input  logic              ack_in,
  input  logic              tc_in,
  output logic              drq_out,
  output logic              drq_oe,
  output logic              irq_out,
  output logic              irq_oe,
  output logic              ack_out,
  output logic              tc_out
);
  localparam logic [ADDR_W-1:0] DOR_A = ADDR_W'(DOR_OFS);
  localparam logic [ADDR_W-1:0] TDR_A = ADDR_W'(TDR_OFS);

  logic [7:0] dor_q;
  logic       pins_en;
  logic       dor_write;

  assign dor_write = wr_en && (addr == DOR_A);

  fdc_dor_regs #(.ADDR_W(ADDR_W), .DOR_OFS(DOR_OFS), .TDR_OFS(TDR_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .dor_q(dor_q), .rdata(rdata), .rdata_oe(rdata_oe));

  fdc_drive_decode #(.NDRV(NDRV)) u_dec (
    .sel(dor_q[1:0]), .motor(dor_q[7:4]), .swap_en(swap_en),
    .ds_n(ds_n), .mtr_n(mtr_n), .drv_code(drv_code), .drv_motor(drv_motor));

  fdc_dma_gate u_gate (
    .mode_i(mode_i), .dma_bit(dor_q[3]), .drq_in(drq_in), .irq_in(irq_in),
    .ack_in(ack_in), .tc_in(tc_in), .pins_en(pins_en),
    .drq_out(drq_out), .drq_oe(drq_oe), .irq_out(irq_out), .irq_oe(irq_oe),
    .ack_out(ack_out), .tc_out(tc_out));

  assign ctl_reset = ~dor_q[2];

  // R2
  dor_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dor_write |=> (!(rd_en && addr == DOR_A) || rdata == $past(wdata)));

  // R3
  soft_reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_reset) |-> $past(dor_write && !wdata[2]));

  // R4
  normal_ds0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_write && !swap_en) |=> (swap_en ||
      ds_n[0] == !($past(wdata[1:0]) == 2'b00 && $past(wdata[4]))));

  // R6
  swap_ds1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_write && swap_en) |=> (!swap_en ||
      ds_n[1] == !($past(wdata[1:0]) == 2'b00 && $past(wdata[5]))));

  // R7
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_write && !wdata[3]) |=> (mode_i == 2'd1 ||
      (!drq_oe && !irq_oe && !ack_out && !tc_out)));

  // R8
  ps2_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |-> (drq_oe && irq_oe));

  // R9
  tape_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == TDR_A) |=> (!(rd_en && addr == TDR_A) ||
      rdata == {6'b0, $past(wdata[1:0])}));
endmodule

// File: tb/fdc_drvsel_tb.sv
module fdc_drvsel_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_i = 0;
  logic swap_en = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, rdata_oe;
  logic [1:0] ds_n, mtr_n, drv_code;
  logic drv_motor, ctl_reset;
  logic drq_in = 0, irq_in = 0, ack_in = 0, tc_in = 0;
  logic drq_out, drq_oe, irq_out, irq_oe, ack_out, tc_out;

  int checks = 0, fails = 0;
  bit done = 0;
  int ref_dor = 0, ref_tdr = 0;

  always #4 clk = ~clk;

  fdc_drvsel u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_dor <= 0;
      ref_tdr <= 0;
    end else if (wr_en) begin
      if (addr == 2) ref_dor <= wdata;
      if (addr == 3) ref_tdr <= wdata % 4;
    end
  end

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  always @(posedge clk) begin
    int sel, m0, m1, e_ds, e_mt, en;
    #2;
    sel = ref_dor % 4; m0 = bitof(ref_dor, 4); m1 = bitof(ref_dor, 5);
    if (!swap_en) begin
      e_ds = 3;
      if (sel == 0 && m0 == 1) e_ds = 2;
      if (sel == 1 && m1 == 1) e_ds = 1;
      e_mt = (m0 ? 0 : 1) + (m1 ? 0 : 2);
      chk("R4 ds_n", ds_n, e_ds);
      chk("R5 mtr_n", mtr_n, e_mt);
    end else begin
      e_ds = 3;
      if (sel == 0 && m1 == 1) e_ds = 1;
      if (sel == 1 && m0 == 1) e_ds = 2;
      e_mt = (m1 ? 0 : 1) + (m0 ? 0 : 2);
      chk("R6 ds_n", ds_n, e_ds);
      chk("R6 mtr_n", mtr_n, e_mt);
    end
    chk("R3 ctl_reset", ctl_reset, bitof(ref_dor, 2) ? 0 : 1);
    en = (mode_i == 1) || bitof(ref_dor, 3) == 1;
    if (mode_i == 1)
      chk("R8 oe", {drq_oe, irq_oe}, 3);
    else
      chk("R7 oe", {drq_oe, irq_oe}, en ? 3 : 0);
    chk("R7 gated", {drq_out, irq_out, ack_out, tc_out},
        en ? {drq_in, irq_in, ack_in, tc_in} : 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, int a, int exp_d, int exp_oe);
    @(negedge clk); addr = 3'(a); rd_en = 1;
    #1;
    chk({req, " rdata"}, rdata, exp_d);
    chk({req, " rdata_oe"}, rdata_oe, exp_oe);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctl_reset", ctl_reset, 1);
    chk("R1 ds_n", ds_n, 3);
    chk("R1 mtr_n", mtr_n, 3);
    rst_n = 1;
    rd("R1 dor", 2, 0, 8'hFF);
    rd("R1 tdr", 3, 0, 8'h03);
    // R11 activation values
    wr(2, 8'h1C); rd("R2", 2, 8'h1C, 8'hFF);
    chk("R11 1C ds", ds_n, 2); chk("R11 1C mtr", mtr_n, 2);
    chk("R11 1C code", drv_code, 0); chk("R11 1C motor", drv_motor, 1);
    wr(2, 8'h2D);
    chk("R11 2D ds", ds_n, 1); chk("R11 2D mtr", mtr_n, 1);
    chk("R11 2D code", drv_code, 1); chk("R11 2D motor", drv_motor, 1);
    wr(2, 8'h4E);
    chk("R11 4E ds", ds_n, 3); chk("R11 4E code", drv_code, 2); chk("R11 4E motor", drv_motor, 1);
    wr(2, 8'h8F);
    chk("R11 8F ds", ds_n, 3); chk("R11 8F code", drv_code, 3); chk("R11 8F motor", drv_motor, 1);
    // R4 R5 other normal patterns
    wr(2, 8'h24); chk("R4 sel0 m1", ds_n, 3); chk("R5 m1", mtr_n, 1);
    wr(2, 8'h15); chk("R4 sel1 m0", ds_n, 3); chk("R5 m0", mtr_n, 2);
    wr(2, 8'h34); chk("R4 both", ds_n, 2);
    // R6 swap
    @(negedge clk); swap_en = 1;
    wr(2, 8'h24); chk("R6 sel0 m1", ds_n, 1); chk("R6 mtr", mtr_n, 2);
    wr(2, 8'h15); chk("R6 sel1 m0", ds_n, 2); chk("R6 mtr", mtr_n, 1);
    wr(2, 8'h14); chk("R6 sel0 m0", ds_n, 3);
    @(negedge clk); swap_en = 0;
    // R9 R10 tape register
    wr(3, 8'hFE); rd("R9 tdr", 3, 2, 8'h03);
    wr(3, 8'h07); rd("R9 tdr", 3, 3, 8'h03);
    // R3 soft reset pulse
    wr(2, 8'hB0); chk("R3 hold", ctl_reset, 1);
    rd("R3 dor kept", 2, 8'hB0, 8'hFF);
    wr(2, 8'hB4); chk("R3 release", ctl_reset, 0);
    rd("R10 tdr after soft reset", 3, 3, 8'h03);
    // R7 R8 DMA gating
    @(negedge clk); drq_in = 1; irq_in = 1; ack_in = 1; tc_in = 1;
    wr(2, 8'h14); chk("R7 AT off", drq_oe, 0); chk("R7 AT ack", ack_out, 0);
    wr(2, 8'h1C); chk("R7 AT on", drq_out, 1); chk("R7 AT tc", tc_out, 1);
    @(negedge clk); mode_i = 2;
    wr(2, 8'h14); chk("R7 M30 off", irq_oe, 0); chk("R7 M30 tc", tc_out, 0);
    @(negedge clk); mode_i = 1;
    @(negedge clk); chk("R8 PS2 oe", drq_oe, 1); chk("R8 PS2 ack", ack_out, 1);
    @(negedge clk); mode_i = 0; drq_in = 0; irq_in = 0; ack_in = 0; tc_in = 0;
    // R12 no access
    rd("R12 other addr", 5, 0, 0);
    @(negedge clk); addr = 2; #1;
    chk("R12 no rd", rdata_oe, 0); chk("R12 no rd data", rdata, 0);
    rd("R10 tdr final", 3, 3, 8'h03);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule